// File: doc/BRIEF.md
# Coprocessor Wide Register Transfer Unit

This block sits beside an instruction pipeline and handles the control-coprocessor instruction words that move 64 bits at once between a pair of general registers and one of three wide system registers: two page-table base pointers and an address-lookup result register. When the valid strobe accompanies an instruction word, the block decodes the word. It then either takes the concatenation of the two general-register read values into the selected system register, or drives that register's value back as two 32-bit write-back results.

Instruction words that are not two-register transfers are sorted into two groups. The single-register forms are forwarded as a decode class for another unit to handle. Data-processing forms are flagged as undefined. The wide register decode is gated by a feature input. While that input is low, every wide read yields zero and every wide write is reported as an error. Writing either table base also requests a one-cycle translation-cache flush.

All outputs are registered, so they appear one clock cycle after the accepted instruction word.

Top module: `cpx_wide_xfer`

## Requirements
- R1: After reset, the three wide registers hold zero, and every output (write enables, flush, error, undefined, single-register strobe) is low.
- R2: An instruction word with bit 25 clear is a two-register transfer. Bit 20 set makes it a read into general registers; bit 20 clear makes it a write to the coprocessor.
- R3: On a wide write, the value stored is {high read value, low read value}. The low general register index is bits [15:12] and the high index is bits [19:16].
- R4: Register select uses CRm = bits [3:0] and opc1 = bits [7:4]. CRm=2 with opc1=0 selects table base 0, CRm=2 with opc1=1 selects table base 1, and CRm=7 with opc1=0 selects the lookup result register.
- R5: A wide read asserts both general-register write enables in the same cycle, one cycle after the accepted word. The low port carries bits [31:0] with the index from bits [15:12]. The high port carries bits [63:32] with the index from bits [19:16].
- R6: A wide write to either table base raises the flush output for exactly one cycle. A write to the lookup result register does not raise it.
- R7: A wide read from an unrecognised select returns zero on both halves. A wide write to an unrecognised select raises the error output for one cycle and changes no register.
- R8: While the feature input is low, every wide read returns zero and every wide write raises the error output without storing.
- R9: A word with bit 25 set and bit 4 clear raises the undefined output for one cycle.
- R10: A word with bit 25 set and bit 4 set raises the single-register strobe for one cycle and touches no wide register.
- R11: With the valid strobe low, no output pulses and no register changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| feat_wide_en | input | 1 | Enables the wide register decode |
| insn_vld | input | 1 | Instruction word valid |
| insn | input | 32 | Coprocessor instruction word |
| gpr_lo_rdata | input | 32 | Value of the general register named by bits [15:12] |
| gpr_hi_rdata | input | 32 | Value of the general register named by bits [19:16] |
| wb_lo_we | output | 1 | Low write-back enable |
| wb_lo_idx | output | 4 | Low write-back register index |
| wb_lo_data | output | 32 | Low write-back data |
| wb_hi_we | output | 1 | High write-back enable |
| wb_hi_idx | output | 4 | High write-back register index |
| wb_hi_data | output | 32 | High write-back data |
| tlb_flush | output | 1 | One-cycle translation-cache flush request |
| wide_err | output | 1 | Wide write to an unrecognised or disabled register |
| undef_insn | output | 1 | Data-processing form taken as undefined |
| single_xfer | output | 1 | Single-register form forwarded |

## Verification
The assertions assume that the read-value inputs are stable and meaningful in the cycle where the valid strobe is high, and that the feature input does not change in that same cycle. The bench drives every word, read value and feature setting together, about half a clock period before the sampling edge. It then drops the strobe at once, so each checked pulse comes from exactly one accepted word. Table rows and directed cases keep the feature input constant while a word is in flight.

// File: rtl/cpx_wide_pkg.sv
package cpx_wide_pkg;
  localparam int unsigned WORD_W = 32;
  localparam int unsigned WIDE_W = 2 * WORD_W;
  localparam int unsigned IDX_W  = 4;
  localparam int unsigned NREG   = 3;

  typedef enum logic [1:0] {
    K_NONE   = 2'd0,
    K_WIDE   = 2'd1,
    K_SINGLE = 2'd2,
    K_UNDEF  = 2'd3
  } kind_e;

  typedef struct packed {
    kind_e            kind;
    logic             rd;
    logic [IDX_W-1:0] lo_idx;
    logic [IDX_W-1:0] hi_idx;
    logic [3:0]       crm;
    logic [3:0]       opc1;
  } dec_t;
endpackage

// File: rtl/cpx_insn_dec.sv
module cpx_insn_dec
  import cpx_wide_pkg::*;
(
  input  logic              vld,
  input  logic [WORD_W-1:0] insn,
  output dec_t              dec
);
  always_comb begin
    dec.rd     = insn[20];
    dec.lo_idx = insn[15:12];
    dec.hi_idx = insn[19:16];
    dec.crm    = insn[3:0];
    dec.opc1   = insn[7:4];
    if (!vld)            dec.kind = K_NONE;
    else if (!insn[25])  dec.kind = K_WIDE;
    else if (insn[4])    dec.kind = K_SINGLE;
    else                 dec.kind = K_UNDEF;
  end
endmodule

// File: rtl/cpx_reg_sel.sv
module cpx_reg_sel
  import cpx_wide_pkg::*;
(
  input  logic            en,
  input  logic [3:0]      crm,
  input  logic [3:0]      opc1,
  output logic [NREG-1:0] hit
);
  // slot 0: table base 0, slot 1: table base 1, slot 2: lookup result
  localparam logic [3:0] SEL_CRM  [NREG] = '{4'd2, 4'd2, 4'd7};
  localparam logic [3:0] SEL_OPC1 [NREG] = '{4'd0, 4'd1, 4'd0};
  for (genvar g = 0; g < NREG; g++) begin : g_sel
    assign hit[g] = en && (crm == SEL_CRM[g]) && (opc1 == SEL_OPC1[g]);
  end
endmodule

// File: rtl/cpx_wide_regs.sv
module cpx_wide_regs
  import cpx_wide_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NREG-1:0]   wr_en,
  input  logic [WIDE_W-1:0] wr_data,
  input  logic [NREG-1:0]   rd_sel,
  output logic [WIDE_W-1:0] rd_data
);
  logic [WIDE_W-1:0] regs_q [NREG];

  for (genvar g = 0; g < NREG; g++) begin : g_reg
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        regs_q[g] <= '0;
      else if (wr_en[g]) regs_q[g] <= wr_data;
    end
  end

  always_comb begin
    rd_data = '0;
    for (int i = 0; i < NREG; i++)
      if (rd_sel[i]) rd_data = rd_data | regs_q[i];
  end

  p_sel_onehot_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(rd_sel) && $onehot0(wr_en));
  p_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en == '0) |=> $stable(regs_q[0]) && $stable(regs_q[1]) && $stable(regs_q[2]));
endmodule

// File: rtl/cpx_wide_xfer.sv
module cpx_wide_xfer
  import cpx_wide_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        feat_wide_en,
  input  logic        insn_vld,
  input  logic [31:0] insn,
  input  logic [31:0] gpr_lo_rdata,
  input  logic [31:0] gpr_hi_rdata,
  output logic        wb_lo_we,
  output logic [3:0]  wb_lo_idx,
  output logic [31:0] wb_lo_data,
  output logic        wb_hi_we,
  output logic [3:0]  wb_hi_idx,
  output logic [31:0] wb_hi_data,
  output logic        tlb_flush,
  output logic        wide_err,
  output logic        undef_insn,
  output logic        single_xfer
);
  dec_t              dec;
  logic [NREG-1:0]   hit;
  logic [NREG-1:0]   wr_en;
  logic [WIDE_W-1:0] rd_val;
  logic              is_wide, is_rd, is_wr;

  cpx_insn_dec u_dec (.vld(insn_vld), .insn(insn), .dec(dec));
  cpx_reg_sel  u_sel (.en(feat_wide_en), .crm(dec.crm), .opc1(dec.opc1), .hit(hit));

  assign is_wide = (dec.kind == K_WIDE);
  assign is_rd   = is_wide && dec.rd;
  assign is_wr   = is_wide && !dec.rd;
  assign wr_en   = is_wr ? hit : '0;

  cpx_wide_regs u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en),
    .wr_data({gpr_hi_rdata, gpr_lo_rdata}),
    .rd_sel(is_rd ? hit : '0), .rd_data(rd_val));

  // next-state
  logic        lo_we_d, hi_we_d, flush_d, err_d, undef_d, single_d;
  logic [3:0]  lo_idx_d, hi_idx_d;
  logic [31:0] lo_data_d, hi_data_d;
  logic        out_en;

  always_comb begin
    lo_we_d   = is_rd;
    hi_we_d   = is_rd;
    lo_idx_d  = dec.lo_idx;
    hi_idx_d  = dec.hi_idx;
    lo_data_d = rd_val[31:0];
    hi_data_d = rd_val[63:32];
    flush_d   = wr_en[0] | wr_en[1];
    err_d     = is_wr && (hit == '0);
    undef_d   = (dec.kind == K_UNDEF);
    single_d  = (dec.kind == K_SINGLE);
    out_en    = is_rd;
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wb_lo_we <= 1'b0; wb_hi_we <= 1'b0;
      tlb_flush <= 1'b0; wide_err <= 1'b0;
      undef_insn <= 1'b0; single_xfer <= 1'b0;
    end else begin
      wb_lo_we <= lo_we_d; wb_hi_we <= hi_we_d;
      tlb_flush <= flush_d; wide_err <= err_d;
      undef_insn <= undef_d; single_xfer <= single_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wb_lo_idx <= '0; wb_hi_idx <= '0;
      wb_lo_data <= '0; wb_hi_data <= '0;
    end else if (out_en) begin
      wb_lo_idx <= lo_idx_d; wb_hi_idx <= hi_idx_d;
      wb_lo_data <= lo_data_d; wb_hi_data <= hi_data_d;
    end
  end

  p_we_pair_r5: assert property (@(posedge clk) disable iff (!rst_n)
    wb_lo_we == wb_hi_we);
  p_flush_one_r6: assert property (@(posedge clk) disable iff (!rst_n)
    tlb_flush |=> !tlb_flush || $past(insn_vld));
  p_class_excl_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({wb_lo_we, tlb_flush | wide_err, undef_insn, single_xfer}));
  p_idle_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !insn_vld |=> !wb_lo_we && !tlb_flush && !wide_err && !undef_insn && !single_xfer);
  p_feat_off_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (insn_vld && !feat_wide_en && !insn[25] && !insn[20]) |=> wide_err && !tlb_flush);
  p_undef_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (insn_vld && insn[25] && !insn[4]) |=> undef_insn);
endmodule

// File: tb/cpx_wide_xfer_bench.sv
module cpx_wide_xfer_bench;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0, rst_n = 1'b0;
  logic feat = 1'b1, vld = 1'b0;
  logic [31:0] insn = '0, glo = '0, ghi = '0;
  logic lwe, hwe, flush, err, und, sgl;
  logic [3:0] lidx, hidx;
  logic [31:0] ldat, hdat;
  int checks = 0, errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  cpx_wide_xfer u_cpx_wide_xfer (
    .clk(clk), .rst_n(rst_n), .feat_wide_en(feat), .insn_vld(vld), .insn(insn),
    .gpr_lo_rdata(glo), .gpr_hi_rdata(ghi),
    .wb_lo_we(lwe), .wb_lo_idx(lidx), .wb_lo_data(ldat),
    .wb_hi_we(hwe), .wb_hi_idx(hidx), .wb_hi_data(hdat),
    .tlb_flush(flush), .wide_err(err), .undef_insn(und), .single_xfer(sgl));

  function automatic logic [31:0] mk(input logic b25, input logic rd,
      input logic [3:0] hi, input logic [3:0] lo, input logic [3:0] opc1,
      input logic b4, input logic [3:0] crm);
    logic [31:0] w;
    w = 32'hEC00_0F00;
    w[25] = b25; w[20] = rd; w[19:16] = hi; w[15:12] = lo;
    w[7:4] = opc1; w[3:0] = crm;
    if (b4) w[4] = 1'b1;
    return w;
  endfunction

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // drive one word, let one edge pass, sample at the next falling edge
  task automatic issue(input logic [31:0] w, input logic [31:0] lo, input logic [31:0] hi);
    @(negedge clk); insn = w; glo = lo; ghi = hi; vld = 1'b1;
    @(posedge clk); #1 vld = 1'b0;
    @(negedge clk);
  endtask

  typedef struct packed {
    logic [31:0] w; logic [31:0] lo; logic [31:0] hi;
    logic [5:0]  flags; // lwe hwe flush err und sgl
    logic [63:0] rdv;
  } vec_t;

  localparam vec_t VEC [10] = '{
    '{32'hEC40_3002 | 32'h0001_0000, 32'h1111_2222, 32'h3333_4444, 6'b001000, 64'h0},
    '{32'hEC50_5002 | 32'h0006_0000, 32'h0, 32'h0, 6'b110000, 64'h3333_4444_1111_2222},
    '{32'hEC40_3012 | 32'h0001_0000, 32'hAAAA_0001, 32'hBBBB_0002, 6'b001000, 64'h0},
    '{32'hEC50_1012 | 32'h0002_0000, 32'h0, 32'h0, 6'b110000, 64'hBBBB_0002_AAAA_0001},
    '{32'hEC40_3007 | 32'h0001_0000, 32'hC0DE_0003, 32'h0000_00FF, 6'b000000, 64'h0},
    '{32'hEC50_2007 | 32'h0003_0000, 32'h0, 32'h0, 6'b110000, 64'h0000_00FF_C0DE_0003},
    '{32'hEC40_3005 | 32'h0001_0000, 32'hDEAD_BEEF, 32'h1, 6'b000100, 64'h0},
    '{32'hEC50_4025 | 32'h0009_0000, 32'h0, 32'h0, 6'b110000, 64'h0},
    '{32'hEE00_0F00, 32'h0, 32'h0, 6'b000010, 64'h0},
    '{32'hEE10_0F10, 32'h0, 32'h0, 6'b000001, 64'h0}
  };

  initial begin
    #(CLK_PERIOD * 150000);
    errors++; checks++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1", {lwe, hwe, flush, err, und, sgl}, 0);
    chk("R1", {ldat, hdat}, 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R2 R3 R4 R5 R6 R7 R9 R10 vector walk
    foreach (VEC[i]) begin
      issue(VEC[i].w, VEC[i].lo, VEC[i].hi);
      chk("R2_R6_R7_R9_R10 flags", {lwe, hwe, flush, err, und, sgl}, VEC[i].flags);
      if (VEC[i].flags[5]) begin
        chk("R3_R5 data", {hdat, ldat}, VEC[i].rdv);
        chk("R5 idx", {hidx, lidx}, {VEC[i].w[19:16], VEC[i].w[15:12]});
      end
      // R6 flush lasts one cycle
      @(negedge clk);
      chk("R6 one cycle", {flush, err, und, sgl, lwe}, 0);
    end

    // R7: unrecognised write changed nothing: re-read table base 0
    issue(mk(0, 1, 4'd1, 4'd0, 4'd0, 0, 4'd2), 0, 0);
    chk("R7 unchanged", {hdat, ldat}, 64'h3333_4444_1111_2222);

    // R8 feature off: write errors, read zero, register retained
    feat = 1'b0;
    issue(mk(0, 0, 4'd1, 4'd3, 4'd0, 0, 4'd2), 32'h5, 32'h6);
    chk("R8 err", {err, flush}, 2'b10);
    issue(mk(0, 1, 4'd1, 4'd0, 4'd0, 0, 4'd2), 0, 0);
    chk("R8 read zero", {lwe, hwe, hdat, ldat}, {2'b11, 64'h0});
    feat = 1'b1;
    issue(mk(0, 1, 4'd1, 4'd0, 4'd0, 0, 4'd2), 0, 0);
    chk("R8 retained", {hdat, ldat}, 64'h3333_4444_1111_2222);

    // R10 single-register form touches nothing
    issue(mk(1, 0, 4'd1, 4'd3, 4'd0, 1, 4'd2), 32'h77, 32'h88);
    chk("R10 single", {sgl, flush}, 2'b10);
    issue(mk(0, 1, 4'd1, 4'd0, 4'd0, 0, 4'd2), 0, 0);
    chk("R10 no write", {hdat, ldat}, 64'h3333_4444_1111_2222);

    // R11 valid low: no pulse, no write
    @(negedge clk); insn = mk(0, 0, 4'd1, 4'd3, 4'd0, 0, 4'd2); glo = 32'h9; ghi = 32'h9;
    @(negedge clk);
    chk("R11 idle", {lwe, hwe, flush, err, und, sgl}, 0);
    issue(mk(0, 1, 4'd1, 4'd0, 4'd0, 0, 4'd2), 0, 0);
    chk("R11 no write", {hdat, ldat}, 64'h3333_4444_1111_2222);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule